// File: doc/BRIEF.md
# Tilt Orientation Classifier with Debounce

This block turns a stream of signed two-axis acceleration samples into a screen orientation. Each sample comes with a one-cycle valid strobe, nominally at 100 Hz. The block sorts each sample into one of four orientations from the signs of the sum and the difference of the two axes. A sample whose stronger axis is too weak to give a reliable answer is marked as tilted, and its classification is discarded.

Two orientation outputs are provided. The instantaneous orientation follows every usable sample. The long-term orientation moves to a new value only after a selectable run of consecutive usable samples that all agree on that new value. A single-cycle change pulse marks each commit, so downstream logic, such as a display rotator or an interrupt source, sees one event per real change and no flicker near the 45-degree boundaries.

Top module: `tilt_orient_top`

## Requirements
- R1: After synchronous reset the long-term orientation is 00, the instantaneous orientation is 00, the tilt flag is 1 and the change pulse is 0.
- R2: A sample is usable only when the larger magnitude of the two axes is strictly greater than 24 counts, so 24 is rejected and 25 or -25 is accepted. -128 is handled as magnitude 128.
- R3: A usable sample maps to an orientation code: sum ≥ 0 and difference < 0 gives 00 (upright); sum ≥ 0 and difference ≥ 0 gives 01 (90° clockwise); sum < 0 and difference ≥ 0 gives 10 (inverted); sum < 0 and difference < 0 gives 11 (90° counterclockwise). The sum and difference are ax+ay and ax−ay, computed without overflow.
- R4: The instantaneous orientation takes the code of every usable sample one clock after its strobe. It keeps its value after an unusable sample and while no strobe arrives.
- R5: The tilt flag is re-evaluated on every strobed sample, one clock after the strobe: 1 if the sample is unusable, 0 otherwise. It holds between strobes.
- R6: The long-term orientation takes a new code on the Nth consecutive usable sample carrying that code. With the 2-bit run select at 00, N is 16.
- R7: An unusable sample breaks the run, and counting starts again from zero.
- R8: A usable sample with a code that differs from the current candidate restarts the run with that code as the new candidate.
- R9: A usable sample whose code equals the current long-term orientation clears the run.
- R10: The change pulse is high for exactly one clock, in the same cycle in which the long-term orientation takes a value different from its previous one. It never rises otherwise.
- R11: The run select values 01, 10 and 11 give N = 32, 64 and 128.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_vld | input | 1 | One-cycle strobe marking a new sample |
| accel_x | input | 8 | X acceleration, two's complement, 64 counts per g |
| accel_y | input | 8 | Y acceleration, two's complement, 64 counts per g |
| run_sel | input | 2 | Run length select: 00=16, 01=32, 10=64, 11=128 |
| orient_now | output | 2 | Instantaneous orientation code |
| orient_long | output | 2 | Debounced long-term orientation code |
| tilt_bad | output | 1 | 1 when the latest sample was too weak to classify |
| orient_chg | output | 1 | One-cycle pulse when the long-term orientation changes |

## Verification
Several rules are checked by assertions on every cycle. The long-term orientation never moves without the change pulse. The pulse never lasts two cycles and always comes with a real value change. A commit always agrees with the instantaneous code. The tilt flag and the instantaneous code hold still between strobes. The run counter stays inside its range. Only the directed scenarios can show the threshold edge at 24 and 25 counts, the code for each quadrant, the exact sample on which a commit lands for each run length, and the ways a run is broken: by a weak sample, by a different code, or by a sample equal to the long-term value.

// File: rtl/tilt_pkg.sv
package tilt_pkg;

    typedef enum logic [1:0] {
        OR_UP  = 2'b00,
        OR_CW  = 2'b01,
        OR_INV = 2'b10,
        OR_CCW = 2'b11
    } orient_e;

    typedef struct packed {
        logic    usable;
        orient_e dir;
    } sample_class_t;

    function automatic orient_e quadrant(input logic sum_neg, input logic diff_neg);
        orient_e q;
        case ({sum_neg, diff_neg})
            2'b01:   q = OR_UP;
            2'b00:   q = OR_CW;
            2'b10:   q = OR_INV;
            default: q = OR_CCW;
        endcase
        return q;
    endfunction

endpackage

// File: rtl/tilt_classify.sv
module tilt_classify
    import tilt_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int MIN_MAG = 24
) (
    input  logic [DATA_W-1:0] accel_x,
    input  logic [DATA_W-1:0] accel_y,
    output sample_class_t     cls
);
    localparam int EXT_W = DATA_W + 1;

    logic signed [EXT_W-1:0] sx, sy, sum_xy, diff_xy;
    logic [EXT_W-1:0] mag_x, mag_y;

    always_comb begin
        sx      = {accel_x[DATA_W-1], accel_x};
        sy      = {accel_y[DATA_W-1], accel_y};
        mag_x   = sx[EXT_W-1] ? EXT_W'(-sx) : EXT_W'(sx);
        mag_y   = sy[EXT_W-1] ? EXT_W'(-sy) : EXT_W'(sy);
        sum_xy  = sx + sy;
        diff_xy = sx - sy;
        cls.usable = (mag_x > EXT_W'(MIN_MAG)) || (mag_y > EXT_W'(MIN_MAG));
        cls.dir    = quadrant(sum_xy[EXT_W-1], diff_xy[EXT_W-1]);
    end

endmodule

// File: rtl/tilt_debounce.sv
module tilt_debounce
    import tilt_pkg::*;
#(
    parameter int SEL_W    = 2,
    parameter int RUN_BASE = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  sample_class_t    cls,
    input  logic [SEL_W-1:0] run_sel,
    output orient_e          orient_long,
    output logic             orient_chg
);
    localparam int CNT_W   = RUN_BASE + (1 << SEL_W);
    localparam int MAX_RUN = 1 << (RUN_BASE + (1 << SEL_W) - 1);

    logic [CNT_W-1:0] cnt_q, cnt_d, run_len;
    orient_e          cand_q, cand_d, long_q;
    logic             commit, chg_q;

    always_comb begin
        run_len = CNT_W'(1) << (RUN_BASE + int'(run_sel));
        cnt_d   = cnt_q;
        cand_d  = cand_q;
        commit  = 1'b0;
        if (strobe) begin
            if (!cls.usable || cls.dir == long_q) begin
                cnt_d = '0;
            end else if (cls.dir == cand_q && cnt_q != '0) begin
                cnt_d = cnt_q + CNT_W'(1);
            end else begin
                cand_d = cls.dir;
                cnt_d  = CNT_W'(1);
            end
            if (cls.usable && cls.dir != long_q && cnt_d >= run_len) begin
                commit = 1'b1;
                cnt_d  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            cand_q <= OR_UP;
            long_q <= OR_UP;
            chg_q  <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            cand_q <= cand_d;
            if (commit) long_q <= cand_d;
            chg_q  <= commit;
        end
    end

    assign orient_long = long_q;
    assign orient_chg  = chg_q;

    a_r10_pulse_single: assert property (@(posedge clk) disable iff (rst)
        chg_q |=> !chg_q);
    a_r10_pulse_on_change: assert property (@(posedge clk) disable iff (rst)
        chg_q |-> long_q != $past(long_q));
    a_r6_move_needs_pulse: assert property (@(posedge clk) disable iff (rst)
        long_q != $past(long_q) |-> chg_q);
    a_r11_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(MAX_RUN));

endmodule

// File: rtl/tilt_orient_top.sv
module tilt_orient_top
    import tilt_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int MIN_MAG  = 24,
    parameter int SEL_W    = 2,
    parameter int RUN_BASE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_vld,
    input  logic [DATA_W-1:0] accel_x,
    input  logic [DATA_W-1:0] accel_y,
    input  logic [SEL_W-1:0]  run_sel,
    output logic [1:0]        orient_now,
    output logic [1:0]        orient_long,
    output logic              tilt_bad,
    output logic              orient_chg
);
    sample_class_t cls;
    orient_e       now_q, long_w;
    logic          tilt_q;

    tilt_classify #(.DATA_W(DATA_W), .MIN_MAG(MIN_MAG)) u_classify (
        .accel_x (accel_x),
        .accel_y (accel_y),
        .cls     (cls)
    );

    tilt_debounce #(.SEL_W(SEL_W), .RUN_BASE(RUN_BASE)) u_debounce (
        .clk         (clk),
        .rst         (rst),
        .strobe      (sample_vld),
        .cls         (cls),
        .run_sel     (run_sel),
        .orient_long (long_w),
        .orient_chg  (orient_chg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            now_q  <= OR_UP;
            tilt_q <= 1'b1;
        end else if (sample_vld) begin
            tilt_q <= !cls.usable;
            if (cls.usable) now_q <= cls.dir;
        end
    end

    assign orient_now  = now_q;
    assign orient_long = long_w;
    assign tilt_bad    = tilt_q;

    a_r5_tilt_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(sample_vld) |-> $stable(tilt_q));
    a_r4_now_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(sample_vld) |-> $stable(now_q));
    a_r6_commit_agrees: assert property (@(posedge clk) disable iff (rst)
        orient_chg |-> long_w == now_q && !tilt_q);

endmodule

// File: tb/tilt_orient_top_bench.sv
`timescale 1ns/1ps
module tilt_orient_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample_vld = 1'b0;
    logic [7:0] accel_x = '0, accel_y = '0;
    logic [1:0] run_sel = 2'b00;
    logic [1:0] orient_now, orient_long;
    logic       tilt_bad, orient_chg;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tilt_orient_top u_tilt_orient_top (
        .clk(clk), .rst(rst), .sample_vld(sample_vld),
        .accel_x(accel_x), .accel_y(accel_y), .run_sel(run_sel),
        .orient_now(orient_now), .orient_long(orient_long),
        .tilt_bad(tilt_bad), .orient_chg(orient_chg)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input int x, input int y);
        @(negedge clk);
        accel_x = 8'(x); accel_y = 8'(y); sample_vld = 1'b1;
        @(negedge clk);
        sample_vld = 1'b0;
    endtask

    // n-1 samples leave the long-term value alone; the nth commits it
    task automatic run_commit(input string req, input int x, input int y,
                              input int n, input int old_v, input int new_v);
        for (int i = 0; i < n - 1; i++) begin
            send(x, y);
            chk({req, " hold"}, orient_long, old_v);
            chk({req, " no pulse"}, orient_chg, 0);
        end
        send(x, y);
        chk({req, " commit"}, orient_long, new_v);
        chk({req, " pulse"}, orient_chg, 1);
        @(negedge clk);
        chk("R10 pulse one cycle", orient_chg, 0);
    endtask

    task automatic t_reset();
        chk("R1 long", orient_long, 0);
        chk("R1 now", orient_now, 0);
        chk("R1 tilt", tilt_bad, 1);
        chk("R1 pulse", orient_chg, 0);
    endtask

    task automatic t_threshold();
        send(24, 0);    chk("R2 24 rejected", tilt_bad, 1);
        send(0, -24);   chk("R2 -24 rejected", tilt_bad, 1);
        send(25, 0);    chk("R2 25 accepted", tilt_bad, 0);
        send(0, 0);     chk("R5 re-evaluated", tilt_bad, 1);
        send(-25, 3);   chk("R2 -25 accepted", tilt_bad, 0);
        send(-128, 0);  chk("R2 -128 accepted", tilt_bad, 0);
        repeat (5) @(negedge clk);
        chk("R5 held without strobe", tilt_bad, 0);
        send(10, -10);  chk("R5 weak sample", tilt_bad, 1);
    endtask

    task automatic t_classify();
        send(0, 64);    chk("R3 upright", orient_now, 0);
        send(64, 0);    chk("R3 clockwise", orient_now, 1);
        send(0, -64);   chk("R3 inverted", orient_now, 2);
        send(-64, 0);   chk("R3 counterclockwise", orient_now, 3);
        send(-128, -128); chk("R3 no overflow", orient_now, 2);
        send(127, 127); chk("R3 sum max", orient_now, 1);
        send(10, 10);   chk("R4 weak keeps now", orient_now, 1);
        repeat (4) @(negedge clk);
        chk("R4 held without strobe", orient_now, 1);
    endtask

    task automatic t_commit16();
        run_sel = 2'b00;
        send(0, 0);
        run_commit("R6 N=16", 64, 0, 16, 0, 1);
    endtask

    task automatic t_break_weak();
        send(0, 0);
        repeat (10) send(0, -64);
        send(5, 5);
        chk("R7 weak breaks run", orient_long, 1);
        run_commit("R7 restart", 0, -64, 16, 1, 2);
    endtask

    task automatic t_break_other();
        send(0, 0);
        repeat (10) send(-64, 0);
        send(0, 64);
        chk("R8 other code", orient_long, 2);
        run_commit("R8 restart", -64, 0, 16, 2, 3);
    endtask

    task automatic t_equal_long();
        send(0, 0);
        repeat (10) send(0, 64);
        send(-64, 0);
        chk("R9 equal clears", orient_long, 3);
        run_commit("R9 restart", 0, 64, 16, 3, 0);
    endtask

    task automatic t_no_change();
        for (int i = 0; i < 40; i++) begin
            send(0, 70);
            chk("R10 no pulse on same code", orient_chg, 0);
        end
        chk("R10 long unchanged", orient_long, 0);
    endtask

    task automatic t_run_sel();
        send(0, 0);
        run_sel = 2'b11;
        run_commit("R11 N=128", 64, 0, 128, 0, 1);
        run_sel = 2'b01;
        run_commit("R11 N=32", 0, -64, 32, 1, 2);
        run_sel = 2'b10;
        run_commit("R11 N=64", -64, 0, 64, 2, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_threshold();
        t_classify();
        t_commit16();
        t_break_weak();
        t_break_other();
        t_equal_long();
        t_no_change();
        t_run_sel();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule